// File: doc/BRIEF.md
# Half-Character Serializer with Loopback Routing

This block models one serial transceiver lane as synchronous logic clocked at the bit rate. It takes a 5-bit half-character every fifth bit clock, which gives two half-characters per 10-bit encoded character. It shifts each one out least significant bit first, one bit per clock, with no gaps between half-characters. The block asserts a ready strobe in the cycle before it samples the parallel input, so the upstream logic knows when to present the next half-character.

Two mode pins route the lane's serial traffic. One pin is active high and turns on the internal transmit-to-receive path. The other pin is active low and turns on the path that sends the received stream back out of the lane. In normal operation the serializer drives the serial output and the serial input feeds the receiver. In parallel loopback the serializer feeds the receiver and the serial output is held high. In serial loopback the serial input goes back out after one register stage, and the receiver still sees the serial input. With both loopbacks on, the serial input goes straight to the output with no register, and the receiver takes the serializer bit.

Top module: `hc_lane`

## Requirements
- R1: `load_ack` is high in exactly one cycle of every `HALF_W` (5). It is first high after the fourth rising edge that follows reset release. `tx_half` is sampled on the rising edge that ends a cycle in which `load_ack` is high.
- R2: Each sampled half-character appears on the transmit bit stream bit 0 first, one bit per clock. Consecutive half-characters follow each other with no idle bit between them.
- R3: Bit 0 of a half-character sampled at edge S appears on the transmit bit stream after edge S+6. Bit k appears after edge S+6+k.
- R4: While reset is low, and after release until bit 0 of the first sampled half-character arrives, the transmit bit stream is 1.
- R5: With `par_lb`=0 and `ser_lb_n`=1 (normal mode), `ser_o` carries the transmit bit stream and `rx_bit` equals `ser_i`.
- R6: With `par_lb`=1 and `ser_lb_n`=1 (parallel loopback), `ser_o` is 1 and `rx_bit` carries the transmit bit stream.
- R7: With `par_lb`=0 and `ser_lb_n`=0 (serial loopback), `ser_o` equals the value `ser_i` had at the previous rising edge, and `rx_bit` equals `ser_i`.
- R8: With `par_lb`=1 and `ser_lb_n`=0 (both loopbacks), `ser_o` equals `ser_i` in the same cycle with no register, and `rx_bit` carries the transmit bit stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_half | input | HALF_W | Parallel half-character, bit 0 sent first |
| load_ack | output | 1 | High in the cycle before `tx_half` is sampled |
| par_lb | input | 1 | Parallel loopback enable, active high |
| ser_lb_n | input | 1 | Serial loopback enable, active low |
| ser_i | input | 1 | Serial line input |
| ser_o | output | 1 | Serial line output |
| rx_bit | output | 1 | Bit delivered to the receive path |

## Verification
Some properties are checked by assertions on every cycle:
- the phase counter wraps when it reaches the last bit;
- the holding register captures the input in each load cycle;
- the shift register reloads from the holding register;
- the output is held high in parallel loopback;
- the one-cycle retiming in serial loopback;
- the unregistered pass-through when both loopbacks are on.

The bench scenarios are the only place that shows the end-to-end six-cycle latency, the bit order, and the gapless joins between half-characters. It does this by sweeping all 32 half-character values through every loopback mode. The same applies to the all-ones filler after reset and to the absolute position of the ready strobe.

// File: rtl/lane_pkg.sv
// Package: shared types for the half-character lane.
// Assumes the two mode pins are static or change only between bit clocks.
package lane_pkg;

    typedef enum logic [1:0] {
        LB_NONE = 2'd0,   // normal lane operation
        LB_PAR  = 2'd1,   // transmit routed to receiver, line output held high
        LB_SER  = 2'd2,   // line input retimed and sent back out
        LB_BOTH = 2'd3    // line input passed straight out, transmit to receiver
    } lb_mode_e;

    // Maps the active-high parallel pin and the active-low serial pin to a mode.
    function automatic lb_mode_e lb_decode(input logic par_on, input logic ser_off_n);
        lb_mode_e m;
        case ({par_on, ser_off_n})
            2'b01:   m = LB_NONE;
            2'b11:   m = LB_PAR;
            2'b00:   m = LB_SER;
            default: m = LB_BOTH;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hc_phase_ctr.sv
// Module: hc_phase_ctr
// Counts bit positions 0..HALF_W-1 inside a half-character and flags the last one.
// Assumes HALF_W >= 2. The count restarts at 0 on synchronous active-low reset.
module hc_phase_ctr #(
    parameter int HALF_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic last
);
    localparam int CW = (HALF_W > 2) ? $clog2(HALF_W) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(HALF_W - 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == LAST_V);

    // Advance the bit position, wrapping after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));

    // R1
    single_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);

endmodule

// File: rtl/hc_serializer.sv
// Module: hc_serializer
// Holds one half-character and shifts the previous one out LSB first.
// Assumes `load` pulses once per HALF_W cycles. Idle fill is logic 1.
module hc_serializer #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] tx_half,
    output logic              tx_bit
);
    logic [HALF_W-1:0] hold;
    logic [HALF_W-1:0] shreg;
    logic              tx_q;

    assign tx_bit = tx_q;

    // Capture the parallel half-character at each load edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '1;
        else if (load)
            hold <= tx_half;
    end

    // Reload from the holding register, otherwise shift right with 1 fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '1;
        else if (load)
            shreg <= hold;
        else
            shreg <= {1'b1, shreg[HALF_W-1:1]};
    end

    // Register the outgoing bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= 1'b1;
        else
            tx_q <= shreg[0];
    end

    // R1
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hold == $past(tx_half)));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shreg == $past(hold)));

endmodule

// File: rtl/lb_router.sv
// Module: lb_router
// Picks the line output and the receiver bit from the loopback mode.
// Assumes the retime flop always samples the line input, whatever the mode.
module lb_router
    import lane_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     tx_bit,
    input  logic     ser_i,
    output logic     ser_o,
    output logic     rx_bit
);
    logic rt_q;

    // One-stage retiming of the line input for serial loopback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rt_q <= 1'b1;
        else
            rt_q <= ser_i;
    end

    // Select the output and receive sources for each mode.
    always_comb begin
        case (mode)
            LB_NONE: begin ser_o = tx_bit; rx_bit = ser_i;  end
            LB_PAR:  begin ser_o = 1'b1;   rx_bit = tx_bit; end
            LB_SER:  begin ser_o = rt_q;   rx_bit = ser_i;  end
            default: begin ser_o = ser_i;  rx_bit = tx_bit; end
        endcase
    end

    // R6
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_PAR) |-> (ser_o && (rx_bit == tx_bit)));

    // R7
    retime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == LB_SER) && $past(rst_n)) |-> (ser_o == $past(ser_i)));

    // R8
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_BOTH) |-> ((ser_o == ser_i) && (rx_bit == tx_bit)));

endmodule

// File: rtl/hc_lane.sv
// Module: hc_lane (top)
// One lane: phase counter, half-character serializer and loopback router.
// Assumes all inputs are synchronous to clk. Reset is synchronous active low.
module hc_lane
    import lane_pkg::*;
#(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] tx_half,
    output logic              load_ack,
    input  logic              par_lb,
    input  logic              ser_lb_n,
    input  logic              ser_i,
    output logic              ser_o,
    output logic              rx_bit
);
    logic     last;
    logic     tx_bit;
    lb_mode_e mode;

    assign mode     = lb_decode(par_lb, ser_lb_n);
    assign load_ack = last;

    hc_phase_ctr #(.HALF_W(HALF_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .last  (last)
    );

    hc_serializer #(.HALF_W(HALF_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (last),
        .tx_half (tx_half),
        .tx_bit  (tx_bit)
    );

    lb_router u_rt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .tx_bit (tx_bit),
        .ser_i  (ser_i),
        .ser_o  (ser_o),
        .rx_bit (rx_bit)
    );

    // R5
    normal_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_NONE) |-> (rx_bit == ser_i));

endmodule

// File: tb/sim_hc_lane.sv
`timescale 1ns/1ps
module sim_hc_lane;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] tx_half;
    logic       load_ack;
    logic       par_lb;
    logic       ser_lb_n;
    logic       ser_i;
    logic       ser_o;
    logic       rx_bit;

    int   nchk = 0;
    int   nerr = 0;
    int   cyc  = 0;
    logic sched_v [64];
    logic sched_b [64];
    logic si_prev = 1'b0;

    always #5 clk = ~clk;

    hc_lane #(.HALF_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_half(tx_half), .load_ack(load_ack),
        .par_lb(par_lb), .ser_lb_n(ser_lb_n), .ser_i(ser_i),
        .ser_o(ser_o), .rx_bit(rx_bit)
    );

    // Edge counter: 0 during reset, n after the n-th edge after release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0b exp=%0b cyc=%0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic pat(input int c);
        return logic'(((c * 5) ^ (c >> 2)) & 1);
    endfunction

    // Monitor in the middle of each cycle.
    always @(negedge clk) begin
        if (rst_n && cyc >= 1) begin
            int   idx;
            logic have;
            logic txe;
            string ttag;
            idx  = cyc % 64;
            have = sched_v[idx];
            txe  = sched_b[idx];
            sched_v[idx] = 1'b0;
            ttag = (cyc <= 10) ? "R4" : "R2 R3";
            // R1: ready strobe position
            chk(load_ack == (cyc % 5 == 4), "R1", load_ack, logic'(cyc % 5 == 4));
            case ({par_lb, ser_lb_n})
                2'b01: begin  // R5
                    if (have) chk(ser_o == txe, {"R5 ", ttag}, ser_o, txe);
                    chk(rx_bit == ser_i, "R5", rx_bit, ser_i);
                end
                2'b11: begin  // R6
                    chk(ser_o == 1'b1, "R6", ser_o, 1'b1);
                    if (have) chk(rx_bit == txe, {"R6 ", ttag}, rx_bit, txe);
                end
                2'b00: begin  // R7
                    chk(ser_o == si_prev, "R7", ser_o, si_prev);
                    chk(rx_bit == ser_i, "R7", rx_bit, ser_i);
                end
                default: begin  // R8
                    chk(ser_o == ser_i, "R8", ser_o, ser_i);
                    if (have) chk(rx_bit == txe, {"R8 ", ttag}, rx_bit, txe);
                end
            endcase
        end
        si_prev = ser_i;
    end

    // Send all 32 half-character values under one loopback mode.
    task automatic run_mode(input logic pl, input logic sln);
        par_lb   = pl;
        ser_lb_n = sln;
        for (int v = 0; v < 32; v++) begin
            forever begin
                @(posedge clk);
                #2;
                ser_i = pat(cyc);
                if (load_ack) break;
            end
            tx_half = 5'(v);
            for (int k = 0; k < 5; k++) begin
                sched_b[(cyc + 1 + 6 + k) % 64] = tx_half[k];
                sched_v[(cyc + 1 + 6 + k) % 64] = 1'b1;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        nerr++;
        $display("FAIL R1 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            sched_v[i] = 1'b0;
            sched_b[i] = 1'b1;
        end
        // R4: filler ones expected for edges 1..10 after release
        for (int i = 1; i <= 10; i++) sched_v[i] = 1'b1;
        rst_n = 1'b0; par_lb = 1'b0; ser_lb_n = 1'b1; ser_i = 1'b0; tx_half = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(ser_o == 1'b1, "R4 in reset", ser_o, 1'b1);
        chk(load_ack == 1'b0, "R1 in reset", load_ack, 1'b0);
        rst_n = 1'b1;
        run_mode(1'b0, 1'b1);   // normal
        run_mode(1'b1, 1'b1);   // parallel loopback
        run_mode(1'b0, 1'b0);   // serial loopback
        run_mode(1'b1, 1'b0);   // both
        run_mode(1'b0, 1'b1);   // normal again
        repeat (14) begin
            @(posedge clk);
            #2;
            ser_i = pat(cyc);
        end
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule